// File: doc/BRIEF.md
# UART Status and Interrupt Register

This block is the status and interrupt-control register of a serial port as a bus master sees it. It keeps two interrupt enables, one for transmit and one for receive, together with a transmit-buffer-empty flag, a receive-data-full flag and three sticky receive error flags: framing, overrun and parity. The transmitter reports when its buffered byte has moved into the shift register. The receiver reports when a byte has been loaded and when an error has been found. The bus decoder reports writes to the transmit data register, reads of the receive data register, and writes to the control bit that clears errors. From this state the block drives the transmit and receive interrupt requests and a receive-data-valid indication. It also presents the whole status byte as bits 15:8 of a 16-bit read word.

The two buffer flags each live in a two-state machine. The transmit machine has the states TXB_EMPTY (the reset state) and TXB_FULL. A transmit data write without a simultaneous load moves it from TXB_EMPTY to TXB_FULL. A load strobe moves it from TXB_FULL back to TXB_EMPTY. The receive machine has the states RXB_EMPTY (the reset state) and RXB_FULL. A load strobe moves it from RXB_EMPTY to RXB_FULL. A data-register read without a simultaneous load moves it from RXB_FULL back to RXB_EMPTY. In every other case each machine stays where it is. The error flags do not clear when the receive data register is read. They clear only when software writes 0 to the error-clear control bit. Any error makes the receive data invalid and raises the receive interrupt when that interrupt is enabled.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset the read word is 16'h0800: only the transmit-buffer-empty flag (bit 11) is 1, and both enables and all other flags are 0.
- R2: A status write (en_wr) loads the transmit enable (bit 8) from en_wdata[0] and the receive enable (bit 9) from en_wdata[1]. The write leaves bits 11 to 15 unchanged. Bit 10 and bits 7:0 always read 0.
- R3: A transmit data write (txd_wr) clears bit 11 at the next clock edge.
- R4: A transmit load strobe (tx_load) sets bit 11 at the next clock edge. If tx_load and txd_wr arrive in the same cycle, bit 11 is set.
- R5: tx_irq is 1 exactly when bit 8 and bit 11 are both 1.
- R6: A receive load strobe (rx_load) sets bit 12, and a receive data read (rxd_rd) clears it. Both take effect at the next edge. If both arrive in the same cycle, bit 12 is set.
- R7: The error strobes set sticky flags: err_set[0] sets framing (bit 13), err_set[1] sets overrun (bit 14) and err_set[2] sets parity (bit 15). Neither a receive data read nor a status write clears them.
- R8: A control write (ctrl_wr) with ctrl_errclr_bit = 0 clears all three error flags at the next edge. With ctrl_errclr_bit = 1 it has no effect. An error strobe that arrives in the same cycle as the clear keeps its own flag set.
- R9: rx_irq is 1 exactly when bit 9 is 1 and at least one of bits 12 to 15 is 1.
- R10: rx_data_valid is 1 exactly when bit 12 is 1 and bits 13 to 15 are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Bus write strobe for the status register |
| en_wdata | input | 2 | Written bits 9:8 (receive enable, transmit enable) |
| txd_wr | input | 1 | Bus write of the transmit data register |
| rxd_rd | input | 1 | Bus read of the receive data register |
| ctrl_wr | input | 1 | Bus write of the control register |
| ctrl_errclr_bit | input | 1 | Value written to the error-clear bit (0 clears) |
| tx_load | input | 1 | Transmitter moved its buffer into the shift register |
| rx_load | input | 1 | Receiver loaded a byte into the receive data register |
| err_set | input | 3 | Error strobes: [0] framing, [1] overrun, [2] parity |
| stat_rdata | output | 16 | Read word; status in bits 15:8 |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| rx_data_valid | output | 1 | Receive data register holds valid data |

## Verification
Three pairs of events can land in the same cycle. A hardware set can meet a software clear on the same flag: tx_load with txd_wr, rx_load with rxd_rd, or an error strobe with an error-clear write. Directed cycles drive each pair together and expect the flag to read 1 afterwards. A long random run then lets the pairs collide freely, and a bench model in which the set always wins judges every cycle's read word, both interrupt lines and the valid output.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    localparam int WORD_W  = 16;
    localparam int ST_BASE = 8;
    localparam int NUM_ERR = 3;
    localparam int TIE_POS  = ST_BASE + 0;
    localparam int RIE_POS  = ST_BASE + 1;
    localparam int TDRE_POS = ST_BASE + 3;
    localparam int RDRF_POS = ST_BASE + 4;
    localparam int ERR_POS  = ST_BASE + 5;

    typedef enum logic {TXB_FULL = 1'b0, TXB_EMPTY = 1'b1} txb_state_e;
    typedef enum logic {RXB_EMPTY = 1'b0, RXB_FULL = 1'b1} rxb_state_e;
endpackage

// File: rtl/uart_st_txbuf.sv
module uart_st_txbuf
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic txd_wr,
    input  logic tx_load,
    output logic empty_o
);
    txb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXB_EMPTY: if (txd_wr && !tx_load) state_d = TXB_FULL;
            TXB_FULL:  if (tx_load)            state_d = TXB_EMPTY;
            default:                           state_d = TXB_EMPTY;
        endcase
    end

    always_comb empty_o = (state_q == TXB_EMPTY);

    // R4: load wins over a simultaneous write
    a_r4_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> empty_o);
    // R3
    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !tx_load) |=> !empty_o);
endmodule

// File: rtl/uart_st_rxbuf.sv
module uart_st_rxbuf
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_load,
    input  logic rxd_rd,
    output logic full_o
);
    rxb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RXB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXB_EMPTY: if (rx_load)            state_d = RXB_FULL;
            RXB_FULL:  if (rxd_rd && !rx_load) state_d = RXB_EMPTY;
            default:                           state_d = RXB_EMPTY;
        endcase
    end

    always_comb full_o = (state_q == RXB_FULL);

    // R6
    a_r6_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> full_o);
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_rd && !rx_load) |=> !full_o);
endmodule

// File: rtl/uart_st_errbank.sv
module uart_st_errbank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_err
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags_o[i] <= 1'b0;
            else if (set_i[i]) flags_o[i] <= 1'b1;
            else if (clr_i)    flags_o[i] <= 1'b0;
        end

        // R7: sticky until cleared
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i) |=> flags_o[i]);
        // R8: clear, unless the same flag is being set
        a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[i]) |=> !flags_o[i]);
    end
endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
    import uart_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr,
    input  logic [1:0]         en_wdata,
    input  logic               txd_wr,
    input  logic               rxd_rd,
    input  logic               ctrl_wr,
    input  logic               ctrl_errclr_bit,
    input  logic               tx_load,
    input  logic               rx_load,
    input  logic [NUM_ERR-1:0] err_set,
    output logic [WORD_W-1:0]  stat_rdata,
    output logic               tx_irq,
    output logic               rx_irq,
    output logic               rx_data_valid
);
    logic               tie_q, rie_q;
    logic               tdre, rdrf;
    logic [NUM_ERR-1:0] err_flags;
    logic               err_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tie_q <= 1'b0;
            rie_q <= 1'b0;
        end else if (en_wr) begin
            tie_q <= en_wdata[0];
            rie_q <= en_wdata[1];
        end
    end

    assign err_clr = ctrl_wr && !ctrl_errclr_bit;

    uart_st_txbuf u_tx (
        .clk(clk), .rst_n(rst_n), .txd_wr(txd_wr), .tx_load(tx_load), .empty_o(tdre)
    );

    uart_st_rxbuf u_rx (
        .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rxd_rd(rxd_rd), .full_o(rdrf)
    );

    uart_st_errbank #(.N(NUM_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .flags_o(err_flags)
    );

    always_comb begin
        stat_rdata                             = '0;
        stat_rdata[TIE_POS]                    = tie_q;
        stat_rdata[RIE_POS]                    = rie_q;
        stat_rdata[TDRE_POS]                   = tdre;
        stat_rdata[RDRF_POS]                   = rdrf;
        stat_rdata[ERR_POS +: NUM_ERR]         = err_flags;
        tx_irq        = tie_q && tdre;
        rx_irq        = rie_q && (rdrf || (|err_flags));
        rx_data_valid = rdrf && !(|err_flags);
    end

    // R5: an enabled transmit load raises the request next cycle
    a_r5_tx_irq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && tie_q && !en_wr) |=> tx_irq);
    // R9: an enabled receive load raises the request next cycle
    a_r9_rx_irq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rie_q && !en_wr) |=> rx_irq);
    // R10: an error strobe makes the data invalid next cycle
    a_r10_err_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set) |=> !rx_data_valid);
    // R2: bit 10 reads zero
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[ST_BASE+2] == 1'b0);
endmodule

// File: tb/uart_stat_reg_test.sv
module uart_stat_reg_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 0, txd_wr = 0, rxd_rd = 0, ctrl_wr = 0, ctrl_errclr_bit = 1;
    logic        tx_load = 0, rx_load = 0;
    logic [1:0]  en_wdata = 0;
    logic [2:0]  err_set = 0;
    logic [15:0] stat_rdata;
    logic        tx_irq, rx_irq, rx_data_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic m_tie, m_rie, m_tdre, m_rdrf;
    logic [2:0] m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_stat_reg uut (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .txd_wr(txd_wr), .rxd_rd(rxd_rd), .ctrl_wr(ctrl_wr),
        .ctrl_errclr_bit(ctrl_errclr_bit), .tx_load(tx_load), .rx_load(rx_load),
        .err_set(err_set), .stat_rdata(stat_rdata), .tx_irq(tx_irq),
        .rx_irq(rx_irq), .rx_data_valid(rx_data_valid)
    );

    function automatic logic [15:0] exp_word();
        return {m_err, m_rdrf, m_tdre, 1'b0, m_rie, m_tie, 8'h00};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_tie = 0; m_rie = 0; m_tdre = 1; m_rdrf = 0; m_err = 0;
    endtask

    task automatic model_step();
        if (en_wr) begin m_tie = en_wdata[0]; m_rie = en_wdata[1]; end
        if (tx_load) m_tdre = 1; else if (txd_wr) m_tdre = 0;
        if (rx_load) m_rdrf = 1; else if (rxd_rd) m_rdrf = 0;
        for (int i = 0; i < 3; i++)
            if (err_set[i]) m_err[i] = 1;
            else if (ctrl_wr && !ctrl_errclr_bit) m_err[i] = 0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " word"}, stat_rdata, exp_word());
        chk("R5 tx_irq", {15'd0, tx_irq}, {15'd0, m_tie & m_tdre});
        chk("R9 rx_irq", {15'd0, rx_irq}, {15'd0, m_rie & (m_rdrf | (|m_err))});
        chk("R10 valid", {15'd0, rx_data_valid}, {15'd0, m_rdrf & ~(|m_err)});
    endtask

    task automatic idle_inputs();
        en_wr = 0; txd_wr = 0; rxd_rd = 0; ctrl_wr = 0; ctrl_errclr_bit = 1;
        tx_load = 0; rx_load = 0; err_set = 0; en_wdata = 0;
    endtask

    // inputs are set by the caller before this; inputs change only at negedge
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        #1;
        check_all(tag);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        model_reset();
        #(CLK_PERIOD*2 + 2);
        // R1 reset state
        check_all("R1");
        chk("R1 word", stat_rdata, 16'h0800);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 enable writes
        en_wr = 1; en_wdata = 2'b11; cycle("R2");
        chk("R2 en", stat_rdata, 16'h0B00);
        // R3 transmit write clears
        txd_wr = 1; cycle("R3");
        chk("R3 tdre", {15'd0, stat_rdata[11]}, 16'd0);
        // R4 both at once: set wins
        txd_wr = 1; tx_load = 1; cycle("R4");
        chk("R4 tdre", {15'd0, stat_rdata[11]}, 16'd1);
        // R6 load, then read with load: set wins, then read clears
        rx_load = 1; cycle("R6");
        rx_load = 1; rxd_rd = 1; cycle("R6");
        chk("R6 rdrf", {15'd0, stat_rdata[12]}, 16'd1);
        rxd_rd = 1; cycle("R6");
        chk("R6 rdrf", {15'd0, stat_rdata[12]}, 16'd0);
        // R7 errors stick through reads and status writes
        rx_load = 1; err_set = 3'b101; cycle("R7");
        rxd_rd = 1; cycle("R7");
        en_wr = 1; en_wdata = 2'b10; cycle("R7");
        chk("R7 err", {13'd0, stat_rdata[15:13]}, 16'd5);
        // R8 clear with bit=1 does nothing
        ctrl_wr = 1; ctrl_errclr_bit = 1; cycle("R8");
        chk("R8 keep", {13'd0, stat_rdata[15:13]}, 16'd5);
        // R8 clear with overrun set simultaneously
        ctrl_wr = 1; ctrl_errclr_bit = 0; err_set = 3'b010; cycle("R8");
        chk("R8 setwins", {13'd0, stat_rdata[15:13]}, 16'd2);
        ctrl_wr = 1; ctrl_errclr_bit = 0; cycle("R8");
        chk("R8 clr", {13'd0, stat_rdata[15:13]}, 16'd0);
        // R10 valid data after a clean load
        rx_load = 1; cycle("R10");
        chk("R10 valid", {15'd0, rx_data_valid}, 16'd1);

        // random run
        for (int n = 0; n < 2000; n++) begin
            en_wr           = ($urandom % 8) == 0;
            en_wdata        = 2'($urandom);
            txd_wr          = ($urandom % 3) == 0;
            tx_load         = ($urandom % 3) == 0;
            rxd_rd          = ($urandom % 3) == 0;
            rx_load         = ($urandom % 3) == 0;
            err_set         = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
            ctrl_wr         = ($urandom % 5) == 0;
            ctrl_errclr_bit = 1'($urandom);
            cycle("R2 R4 R6 R8 random");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(CLK_PERIOD * 100000);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule